// File: doc/BRIEF.md
# Register file with pointer pairs

This block is the general purpose operand store of a small 8-bit microcontroller core. It holds thirty-two 8-bit registers. Two combinational read ports feed the operand buses, and one synchronous byte write port takes back the result of an operation. All of these can be used in the same clock cycle.

The six highest registers can also be used as three 16-bit address pointers, called X, Y and Z. A separate pointer port reads a whole pair at once, and can write a whole pair back on one clock edge. An address-generation stage can therefore fetch a pointer and store its post-incremented or pre-decremented value without spending two cycles. A byte write and a pointer write can happen in the same cycle. When both touch the same register, the byte port wins.

Top module: `rfp_regfile`

## Requirements
- R1: A synchronous active-high `rst` sampled at a rising clock edge clears all 32 registers to 0x00.
- R2: When `wr_en` is high at a rising edge, register `wr_addr` (0 to 31) takes `wr_data` and no other register is changed by the byte port.
- R3: The two read ports are independent and combinational: `rd_data_a` shows register `rd_addr_a` and `rd_data_b` shows register `rd_addr_b` in the same cycle.
- R4: There is no write-through path. During a cycle in which a register is being written, a read of that register returns the value it held before the edge.
- R5: `ptr_rd_data` combinationally shows the pair chosen by `ptr_sel`. 0 gives X = {r27, r26}, 1 gives Y = {r29, r28}, 2 gives Z = {r31, r30}, with the high byte in bits 15:8. Select value 3 reads 0x0000.
- R6: When `ptr_wr_en` is high with `ptr_sel` equal to 0, 1 or 2, both bytes of the chosen pair take `ptr_wr_data` on the same edge: bits 15:8 go to the odd register and bits 7:0 to the even one.
- R7: A pointer write with `ptr_sel` equal to 3 changes no register.
- R8: If a byte write and a pointer write hit the same register in one cycle, that register takes `wr_data`. The other byte of the pair still takes its half of `ptr_wr_data`.
- R9: The byte view and the pointer view share storage. A byte write to r26 to r31 shows up in the pointer read, and a pointer write shows up in the byte reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr_a | input | 5 | Read port A register number |
| rd_data_a | output | 8 | Read port A data |
| rd_addr_b | input | 5 | Read port B register number |
| rd_data_b | output | 8 | Read port B data |
| wr_en | input | 1 | Byte write enable |
| wr_addr | input | 5 | Byte write register number |
| wr_data | input | 8 | Byte write data |
| ptr_sel | input | 2 | Pointer select: 0 X, 1 Y, 2 Z, 3 reserved |
| ptr_rd_data | output | 16 | Selected pointer pair, high byte in 15:8 |
| ptr_wr_en | input | 1 | Pointer pair write enable |
| ptr_wr_data | input | 16 | Pointer pair write data |

## Verification
The hardest case to reach is a collision between the two write paths. The stimulus must raise the byte port and the pointer port on the same edge, aim the byte address at one half of the selected pair, and then confirm that each half took data from a different source. The bench reaches it with a vector that writes r28 and pair Y together. A second vector fires both ports at disjoint targets, which shows that the priority logic is not overly broad. The absence of a bypass is shown by sampling a read port between the drive and the edge while that same register is being written.

// File: rtl/rfp_pkg.sv
package rfp_pkg;

    localparam int RF_DEPTH = 32;
    localparam int RF_WIDTH = 8;
    localparam int RF_NPAIR = 3;

    typedef enum logic [1:0] {
        PSEL_X   = 2'd0,
        PSEL_Y   = 2'd1,
        PSEL_Z   = 2'd2,
        PSEL_RSV = 2'd3
    } ptr_sel_e;

endpackage

// File: rtl/rfp_rd_port.sv
module rfp_rd_port #(
    parameter int NREGS = 32,
    parameter int W     = 8,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic [NREGS-1:0][W-1:0] regs,
    input  logic [AW-1:0]           addr,
    output logic [W-1:0]            data
);

    // plain combinational mux of the current contents, no bypass
    always_comb begin
        data = regs[addr];
    end

endmodule

// File: rtl/rfp_ptr_view.sv
module rfp_ptr_view #(
    parameter int W     = 8,
    parameter int NPAIR = 3,
    localparam int NUP  = 2 * NPAIR
) (
    input  logic [NUP-1:0][W-1:0] upper,
    input  rfp_pkg::ptr_sel_e     sel,
    output logic [2*W-1:0]        ptr
);
    import rfp_pkg::*;

    always_comb begin
        unique case (sel)
            PSEL_X:  ptr = {upper[1], upper[0]};
            PSEL_Y:  ptr = {upper[3], upper[2]};
            PSEL_Z:  ptr = {upper[5], upper[4]};
            default: ptr = '0;
        endcase
    end

endmodule

// File: rtl/rfp_wr_steer.sv
module rfp_wr_steer #(
    parameter int NREGS = 32,
    parameter int W     = 8,
    parameter int NPAIR = 3,
    localparam int AW   = $clog2(NREGS),
    localparam int PBASE = NREGS - 2 * NPAIR
) (
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [W-1:0]            wr_data,
    input  logic                    ptr_wr_en,
    input  rfp_pkg::ptr_sel_e       ptr_sel,
    input  logic [2*W-1:0]          ptr_wr_data,
    output logic [NREGS-1:0]        wr_mask,
    output logic [NREGS-1:0][W-1:0] wr_val
);
    import rfp_pkg::*;

    logic ptr_valid;
    logic [AW-1:0] pair_lo;

    always_comb begin
        ptr_valid = ptr_wr_en && (ptr_sel != PSEL_RSV);
        pair_lo   = AW'(PBASE) + {{(AW-2){1'b0}}, ptr_sel[0], 1'b0}
                  + {{(AW-3){1'b0}}, ptr_sel[1], 2'b00};
    end

    for (genvar gi = 0; gi < NREGS; gi++) begin : g_reg
        localparam logic [AW-1:0] IDX = AW'(gi);
        logic byte_hit;
        logic ptr_hit;

        always_comb begin
            byte_hit = wr_en && (wr_addr == IDX);
            ptr_hit  = ptr_valid && (IDX[AW-1:1] == pair_lo[AW-1:1]);
            wr_mask[gi] = byte_hit || ptr_hit;
            if (byte_hit) begin
                wr_val[gi] = wr_data;
            end else if (IDX[0]) begin
                wr_val[gi] = ptr_wr_data[2*W-1:W];
            end else begin
                wr_val[gi] = ptr_wr_data[W-1:0];
            end
        end
    end

endmodule

// File: rtl/rfp_regfile.sv
module rfp_regfile #(
    parameter int NREGS = rfp_pkg::RF_DEPTH,
    parameter int W     = rfp_pkg::RF_WIDTH,
    parameter int NPAIR = rfp_pkg::RF_NPAIR,
    localparam int AW   = $clog2(NREGS),
    localparam int PBASE = NREGS - 2 * NPAIR
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [AW-1:0]  rd_addr_a,
    output logic [W-1:0]   rd_data_a,
    input  logic [AW-1:0]  rd_addr_b,
    output logic [W-1:0]   rd_data_b,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [W-1:0]   wr_data,
    input  logic [1:0]     ptr_sel,
    output logic [2*W-1:0] ptr_rd_data,
    input  logic           ptr_wr_en,
    input  logic [2*W-1:0] ptr_wr_data
);
    import rfp_pkg::*;

    localparam int NRD = 2;

    typedef struct packed {
        logic [NREGS-1:0][W-1:0] regs;
    } rf_state_t;

    rf_state_t state_d;
    rf_state_t state_q;

    ptr_sel_e                ptr_sel_e_w;
    logic [NREGS-1:0]        wr_mask;
    logic [NREGS-1:0][W-1:0] wr_val;
    logic [NRD-1:0][AW-1:0]  rd_addr_v;
    logic [NRD-1:0][W-1:0]   rd_data_v;

    assign ptr_sel_e_w = ptr_sel_e'(ptr_sel);

    rfp_wr_steer #(.NREGS(NREGS), .W(W), .NPAIR(NPAIR)) u_steer (
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .ptr_wr_en   (ptr_wr_en),
        .ptr_sel     (ptr_sel_e_w),
        .ptr_wr_data (ptr_wr_data),
        .wr_mask     (wr_mask),
        .wr_val      (wr_val)
    );

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < NREGS; i++) begin
            if (wr_mask[i]) begin
                state_d.regs[i] = wr_val[i];
            end
        end
        if (rst) begin
            state_d.regs = '0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign rd_addr_v[0] = rd_addr_a;
    assign rd_addr_v[1] = rd_addr_b;

    for (genvar gp = 0; gp < NRD; gp++) begin : g_rd
        rfp_rd_port #(.NREGS(NREGS), .W(W)) u_rd (
            .regs (state_q.regs),
            .addr (rd_addr_v[gp]),
            .data (rd_data_v[gp])
        );
    end

    assign rd_data_a = rd_data_v[0];
    assign rd_data_b = rd_data_v[1];

    rfp_ptr_view #(.W(W), .NPAIR(NPAIR)) u_view (
        .upper (state_q.regs[NREGS-1:PBASE]),
        .sel   (ptr_sel_e_w),
        .ptr   (ptr_rd_data)
    );

    // ---------------- assertions ----------------
    logic [AW-1:0] chk_lo;
    logic [AW-1:0] chk_hi;
    logic          chk_ptr_ok;
    logic          chk_clash;

    always_comb begin
        chk_lo     = AW'(PBASE + 2 * int'(ptr_sel));
        chk_hi     = chk_lo + AW'(1);
        chk_ptr_ok = ptr_wr_en && (ptr_sel != 2'd3);
        chk_clash  = wr_en && ((wr_addr == chk_lo) || (wr_addr == chk_hi));
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (state_q.regs == '0));

    // R2
    byte_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (state_q.regs[$past(wr_addr)] == $past(wr_data)));

    // R6
    pair_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (chk_ptr_ok && !chk_clash) |=>
        ({state_q.regs[$past(chk_hi)], state_q.regs[$past(chk_lo)]} == $past(ptr_wr_data)));

    // R7
    reserved_sel_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (ptr_wr_en && (ptr_sel == 2'd3) && !wr_en) |=> $stable(state_q.regs));

    // R8
    clash_other_half_chk: assert property (@(posedge clk) disable iff (rst)
        (chk_ptr_ok && chk_clash) |=>
        (state_q.regs[$past(wr_addr) ^ AW'(1)] ==
         ($past(wr_addr[0]) ? $past(ptr_wr_data[W-1:0]) : $past(ptr_wr_data[2*W-1:W]))));

endmodule

// File: tb/rfp_regfile_test.sv
module rfp_regfile_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  rd_addr_a, rd_addr_b, wr_addr;
    logic [7:0]  rd_data_a, rd_data_b, wr_data;
    logic        wr_en, ptr_wr_en;
    logic [1:0]  ptr_sel;
    logic [15:0] ptr_rd_data, ptr_wr_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    rfp_regfile uut (
        .clk(clk), .rst(rst),
        .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ptr_sel(ptr_sel), .ptr_rd_data(ptr_rd_data),
        .ptr_wr_en(ptr_wr_en), .ptr_wr_data(ptr_wr_data)
    );

    typedef struct packed {
        logic        we;
        logic [4:0]  wa;
        logic [7:0]  wd;
        logic        pe;
        logic [1:0]  ps;
        logic [15:0] pd;
        logic [4:0]  ca;
        logic [7:0]  ea;
        logic [1:0]  cs;
        logic [15:0] ep;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 5'd5,  8'h3C, 1'b0, 2'd0, 16'h0000, 5'd5,  8'h3C, 2'd0, 16'h0000}, // R2
        '{1'b1, 5'd26, 8'h11, 1'b0, 2'd0, 16'h0000, 5'd26, 8'h11, 2'd0, 16'h0011}, // R9
        '{1'b0, 5'd0,  8'h00, 1'b1, 2'd1, 16'hBEEF, 5'd29, 8'hBE, 2'd1, 16'hBEEF}, // R6
        '{1'b0, 5'd0,  8'h00, 1'b1, 2'd2, 16'h1234, 5'd30, 8'h34, 2'd2, 16'h1234}, // R5
        '{1'b0, 5'd0,  8'h00, 1'b1, 2'd3, 16'hFFFF, 5'd31, 8'h12, 2'd2, 16'h1234}, // R7
        '{1'b1, 5'd28, 8'h55, 1'b1, 2'd1, 16'hA0A1, 5'd28, 8'h55, 2'd1, 16'hA055}, // R8
        '{1'b1, 5'd31, 8'h77, 1'b1, 2'd0, 16'hCAFE, 5'd27, 8'hCA, 2'd2, 16'h7734}, // R8
        '{1'b1, 5'd0,  8'hFF, 1'b0, 2'd0, 16'h0000, 5'd0,  8'hFF, 2'd0, 16'hCAFE}  // R2
    };

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 1'b0; ptr_wr_en = 1'b0;
        wr_addr = '0; wr_data = '0; ptr_wr_data = '0;
    endtask

    initial begin
        rst = 1'b1; idle();
        rd_addr_a = '0; rd_addr_b = '0; ptr_sel = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: every register reads zero after reset
        for (int i = 0; i < 32; i++) begin
            rd_addr_a = 5'(i);
            #1 chk("R1", {8'h00, rd_data_a}, 16'h0000);
        end
        for (int s = 0; s < 3; s++) begin
            ptr_sel = 2'(s);
            #1 chk("R1", ptr_rd_data, 16'h0000);
        end

        // vector table
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            wr_en = VECS[v].we; wr_addr = VECS[v].wa; wr_data = VECS[v].wd;
            ptr_wr_en = VECS[v].pe; ptr_sel = VECS[v].ps; ptr_wr_data = VECS[v].pd;
            @(posedge clk);
            #1;
            idle();
            rd_addr_a = VECS[v].ca;
            ptr_sel   = VECS[v].cs;
            #1 chk($sformatf("vector %0d R2/R5/R6/R7/R8/R9", v), {8'h00, rd_data_a}, {8'h00, VECS[v].ea});
            chk($sformatf("vector %0d R5 pointer", v), ptr_rd_data, VECS[v].ep);
        end

        // R3: independent ports in one cycle
        @(negedge clk);
        rd_addr_a = 5'd5; rd_addr_b = 5'd0;
        #1 chk("R3 port a", {8'h00, rd_data_a}, 16'h003C);
        chk("R3 port b", {8'h00, rd_data_b}, 16'h00FF);

        // R4: no bypass, old value while writing
        wr_en = 1'b1; wr_addr = 5'd5; wr_data = 8'h99;
        #1 chk("R4 old value", {8'h00, rd_data_a}, 16'h003C);
        @(posedge clk);
        #1 idle();
        #1 chk("R4 new value after edge", {8'h00, rd_data_a}, 16'h0099);

        // R5: reserved select reads zero, X still intact
        ptr_sel = 2'd3;
        #1 chk("R5 reserved read", ptr_rd_data, 16'h0000);
        ptr_sel = 2'd0;
        #1 chk("R5 X pair", ptr_rd_data, 16'hCAFE);

        // R1: reset after activity
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1 rst = 1'b0;
        rd_addr_a = 5'd5; rd_addr_b = 5'd0; ptr_sel = 2'd2;
        #1 chk("R1 after use a", {8'h00, rd_data_a}, 16'h0000);
        chk("R1 after use b", {8'h00, rd_data_b}, 16'h0000);
        chk("R1 after use Z", ptr_rd_data, 16'h0000);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule